// File: doc/BRIEF.md
# Three-Stage CIC Upsampling Filter

This block raises the sample rate of a 16-bit signed stream by a factor of 16 with a cascaded integrator-comb structure of order three and unit differential delay. The block is clocked at the high (output) rate. A one-cycle strobe marks each new input sample. The three difference stages work only on strobed cycles. Their result enters the integrator cascade on exactly one clock, and zero enters on every other clock. The three integrators then run on every clock. The overall response is (1 - z^-16)^3 / (1 - z^-1)^3.

All arithmetic is carried in a 28-bit two's-complement word that wraps without saturation, so the overflow the integrators pick up is removed again by the differences. Every subtraction and every addition feeds a register. The comb side holds three previous-sample registers and three difference registers. The integrator side holds three input registers and three accumulators. A parameter chooses the output form. The truncated form is 16 bits and removes the 2^8 passband gain of the cascade. The wide form is the whole 28-bit accumulator.

Top module: `cic_upsampler`

## Requirements
- R1: A synchronous reset clears every stage register; out_sample is 0 on the cycle after a reset edge and stays 0 until a strobed sample reaches the output.
- R2: in_sample is taken only on cycles where in_strobe is 1; its value on any other cycle has no effect on out_sample.
- R3: Each strobed sample, after the difference stages, enters the integrator cascade on exactly one clock, and zero enters on every other clock. An impulse of amplitude A followed by zero samples strobed every 16 clocks gives a wide output of exactly 46 nonzero values whose sum is 4096*A.
- R4: The result of a sample strobed at clock edge E first appears at the output after edge E+8. For an impulse of amplitude A from a cleared state, the wide output is 0 after edges E through E+7 and A after edge E+8.
- R5: In truncated mode (OUT_MODE = OUT_TRUNC), out_sample is accumulator bits [23:8], the lowest bit being (ORDER-1)*log2(RATE). A constant input x strobed every 16 clocks settles to out_sample = x.
- R6: In wide mode (OUT_MODE = OUT_WIDE), out_sample is the full 28-bit accumulator. A constant input x strobed every 16 clocks settles to 256*x.
- R7: All arithmetic wraps modulo 2^28 with no saturation. After full-scale alternating input (32767, -32768) and then enough zero samples, the output returns to exactly 0.
- R8: On every clock, the wide output after edge k+8 equals the ideal filter value after edge k. That value is the triple running sum, over clocks, of x[n] - 3x[n-1] + 3x[n-2] - x[n-3], inserted on the strobed clocks, modulo 2^28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate clock; one integrator step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| in_strobe | input | 1 | Marks the cycle on which in_sample is a new input sample |
| in_sample | input | IN_W (16) | Signed input sample |
| out_sample | output | OUT_W (16 or 28) | Signed filtered output at the high rate |

## Verification
The bench builds two copies with the default order 3, rate 16 and 28-bit accumulator, one in truncated mode and one in wide mode, and feeds both the same stimulus. The wide copy makes the exact impulse response reachable: its length, its first value and the timing of that value, and its sum. The truncated copy shows the effect of the fixed bit window on steady levels. Since both share one ideal model, any difference in gain, bit selection or modulo behaviour shows up as a mismatch on a specific cycle.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Output form selected at build time
  typedef enum logic {
    OUT_TRUNC = 1'b0,
    OUT_WIDE  = 1'b1
  } cic_out_e;

  // Lowest accumulator bit kept in truncated mode: the cascade gain is
  // RATE^ORDER / RATE, i.e. 2^((ORDER-1)*log2(RATE))
  function automatic int gain_shift(input int order, input int rate_log2);
    return (order - 1) * rate_log2;
  endfunction

endpackage

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out,
  output logic [W-1:0] hold
);

  // Modulo-2^W difference of the current and the previous input-rate sample
  function automatic logic [W-1:0] comb_diff(input logic [W-1:0] cur,
                                             input logic [W-1:0] prev);
    return cur - prev;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      d_out <= '0;
      hold  <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        d_out <= comb_diff(d_in, hold);
        hold  <= d_in;
      end
    end
  end

endmodule

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] acc
);

  logic [W-1:0] pipe_q;

  // Modulo-2^W running sum step
  function automatic logic [W-1:0] integ_step(input logic [W-1:0] acc_cur,
                                              input logic [W-1:0] inc);
    return acc_cur + inc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      acc    <= '0;
    end else begin
      pipe_q <= d_in;
      acc    <= integ_step(acc, pipe_q);
    end
  end

endmodule

// File: rtl/cic_upsampler.sv
module cic_upsampler
  import cic_pkg::*;
#(
  parameter int       IN_W     = 16,
  parameter int       ACC_W    = 28,
  parameter int       RATE     = 16,
  parameter int       ORDER    = 3,
  parameter cic_out_e OUT_MODE = OUT_TRUNC,
  parameter int       OUT_W    = (OUT_MODE == OUT_WIDE) ? ACC_W : IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_strobe,
  input  logic [IN_W-1:0]  in_sample,
  output logic [OUT_W-1:0] out_sample
);

  localparam int RATE_LOG2 = $clog2(RATE);
  localparam int SHIFT     = gain_shift(ORDER, RATE_LOG2);
  localparam int EXT_W     = ACC_W - IN_W;

  // Comb chain: index 0 is the widened input, index ORDER feeds the expander
  logic [ORDER:0]   c_v;
  logic [ACC_W-1:0] c_d [ORDER+1];
  logic [ACC_W-1:0] c_h [ORDER];

  // Integrator chain: index 0 is the zero-stuffed word
  logic [ACC_W-1:0] i_d [ORDER+1];

  // Named internal events for the checker
  logic             feed_valid;
  logic [ACC_W-1:0] feed_word;

  assign c_v[0] = in_strobe;
  assign c_d[0] = {{EXT_W{in_sample[IN_W-1]}}, in_sample};

  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    cic_comb_stage #(.W(ACC_W)) u_comb (
      .clk   (clk),
      .rst   (rst),
      .v_in  (c_v[g]),
      .d_in  (c_d[g]),
      .v_out (c_v[g+1]),
      .d_out (c_d[g+1]),
      .hold  (c_h[g])
    );
  end

  // Rate expander: the difference result on its one valid tick, zero otherwise
  assign feed_valid = c_v[ORDER];
  assign feed_word  = feed_valid ? c_d[ORDER] : '0;
  assign i_d[0]     = feed_word;

  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    cic_integ_stage #(.W(ACC_W)) u_integ (
      .clk  (clk),
      .rst  (rst),
      .d_in (i_d[g]),
      .acc  (i_d[g+1])
    );
  end

  if (OUT_MODE == OUT_WIDE) begin : g_out_wide
    assign out_sample = i_d[ORDER];
  end else begin : g_out_trunc
    assign out_sample = i_d[ORDER][SHIFT +: IN_W];
  end

endmodule

// File: rtl/cic_upsampler_chk.sv
module cic_upsampler_chk #(
  parameter int ORDER = 3,
  parameter int ACC_W = 28,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [ORDER:0]   stage_v,
  input logic [ACC_W-1:0] stage_d [ORDER+1],
  input logic [ACC_W-1:0] hold [ORDER],
  input logic             feed_valid,
  input logic [ACC_W-1:0] first_acc,
  input logic [OUT_W-1:0] out_sample
);

  // Strobe history rebuilt by the checker, one bit per comb stage
  logic [ORDER-1:0] strobe_dly;

  always_ff @(posedge clk) begin
    if (rst) strobe_dly <= '0;
    else     strobe_dly <= (strobe_dly << 1) | ORDER'(stage_v[0]);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> out_sample == '0);

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !stage_v[g] |=> $stable(hold[g]));
    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
      stage_v[g] |=> hold[g] == $past(stage_d[g]));
  end

  // R4
  feed_timing_chk: assert property (@(posedge clk) disable iff (rst)
    feed_valid == strobe_dly[ORDER-1]);

  // R3
  zero_stuff_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(feed_valid, 2) |-> $stable(first_acc));

endmodule

bind cic_upsampler cic_upsampler_chk #(
  .ORDER (ORDER),
  .ACC_W (ACC_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stage_v    (c_v),
  .stage_d    (c_d),
  .hold       (c_h),
  .feed_valid (feed_valid),
  .first_acc  (i_d[1]),
  .out_sample (out_sample)
);

// File: tb/cic_upsampler_test.sv
`timescale 1ns/1ps
module cic_upsampler_test;
  import cic_pkg::*;

  localparam int IN_W  = 16;
  localparam int ACC_W = 28;
  localparam int RATE  = 16;
  localparam int ORDER = 3;
  localparam int LAT   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_strobe = 1'b0;
  logic [IN_W-1:0]   in_sample = '0;
  logic [IN_W-1:0]   out_t;
  logic [ACC_W-1:0]  out_w;

  cic_upsampler #(.IN_W(IN_W), .ACC_W(ACC_W), .RATE(RATE), .ORDER(ORDER),
                  .OUT_MODE(OUT_TRUNC), .OUT_W(IN_W)) uut (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_sample(in_sample),
    .out_sample(out_t));

  cic_upsampler #(.IN_W(IN_W), .ACC_W(ACC_W), .RATE(RATE), .ORDER(ORDER),
                  .OUT_MODE(OUT_WIDE), .OUT_W(ACC_W)) uut_wide (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_sample(in_sample),
    .out_sample(out_w));

  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R8";

  // Ideal model state (input-domain history and three running sums)
  logic signed [ACC_W-1:0] xh [4];
  logic signed [ACC_W-1:0] m1, m2, m3;
  logic        [ACC_W-1:0] sb_q [$];

  task automatic check(input string req, input longint got, input longint exp,
                       input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint sx_t(input logic [IN_W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint sx_w(input logic [ACC_W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) xh[i] = '0;
    m1 = '0; m2 = '0; m3 = '0;
    sb_q.delete();
  endtask

  // One high-rate tick of the ideal filter, pushed into the scoreboard
  task automatic model_edge(input logic s, input logic [IN_W-1:0] x);
    logic signed [ACC_W-1:0] u;
    u = '0;
    if (s) begin
      xh[3] = xh[2]; xh[2] = xh[1]; xh[1] = xh[0];
      xh[0] = ACC_W'($signed(x));
      u = xh[0] - xh[1] * 3 + xh[2] * 3 - xh[3];
    end
    m1 = m1 + u;
    m2 = m2 + m1;
    m3 = m3 + m2;
    sb_q.push_back(m3);
  endtask

  task automatic drive(input logic s, input logic [IN_W-1:0] x);
    @(negedge clk);
    in_strobe = s;
    in_sample = x;
    @(posedge clk);
    #1;
    model_edge(s, x);
  endtask

  // One input sample followed by RATE-1 unstrobed ticks carrying junk
  task automatic send(input logic [IN_W-1:0] x, input logic [IN_W-1:0] junk);
    drive(1'b1, x);
    for (int i = 1; i < RATE; i++) drive(1'b0, junk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    model_clear();
    check("R1", sx_t(out_t), 0, "truncated output in reset");
    check("R1", sx_w(out_w), 0, "wide output in reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    model_edge(1'b0, '0);
  endtask

  // Monitor: compares both instances against the scoreboard every cycle
  initial begin
    logic [ACC_W-1:0] e;
    forever begin
      @(posedge clk);
      #2;
      if (!rst && sb_q.size() > LAT) begin
        e = sb_q.pop_front();
        check(phase, sx_t(out_t), sx_t(e[8 +: IN_W]), "truncated vs model");
        check(phase, sx_w(out_w), sx_w(e), "wide vs model");
      end
    end
  end

  // Watchdog
  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint sum_w;
    int     nz;
    model_clear();

    // R1: reset state, then R2: idle junk without strobes keeps output 0
    phase = "R1";
    do_reset();
    phase = "R2";
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 16'h5a5a + 16'(i));
      check("R2", sx_t(out_t), 0, "idle truncated output");
      check("R2", sx_w(out_w), 0, "idle wide output");
    end

    // R4 latency and R3 impulse length/sum, from a cleared state
    do_reset();
    phase = "R3";
    sum_w = 0;
    nz = 0;
    for (int j = 0; j < 100; j++) begin
      drive((j % RATE) == 0, (j == 0) ? 16'd1000 : 16'd0);
      if (j < LAT) check("R4", sx_w(out_w), 0, "wide output before latency");
      if (j == LAT) check("R4", sx_w(out_w), 1000, "first impulse output");
      if (j >= LAT) begin
        sum_w += sx_w(out_w);
        if (out_w != '0) nz++;
      end
    end
    check("R3", nz, 46, "impulse response length");
    check("R3", sum_w, 4096 * 1000, "impulse response sum");

    // R5/R6 positive DC with junk between strobes (R2)
    phase = "R5";
    for (int n = 0; n < 11; n++) send(16'd1234, 16'h7abc);
    drive(1'b1, 16'd1234);
    for (int i = 1; i < RATE; i++) begin
      drive(1'b0, 16'h8123);
      check("R5", sx_t(out_t), 1234, "DC truncated level");
      check("R6", sx_w(out_w), 1234 * 256, "DC wide level");
    end

    // R5/R6 negative DC
    for (int n = 0; n < 11; n++) send(16'(-700), 16'h1111);
    drive(1'b1, 16'(-700));
    for (int i = 1; i < RATE; i++) begin
      drive(1'b0, 16'hffff);
      check("R5", sx_t(out_t), -700, "negative DC truncated level");
      check("R6", sx_w(out_w), -700 * 256, "negative DC wide level");
    end

    // R7: full-scale alternation wraps, then returns to zero
    phase = "R7";
    for (int n = 0; n < 20; n++) send((n % 2) ? 16'h8000 : 16'h7fff, 16'h0);
    for (int n = 0; n < 8; n++) send(16'd0, 16'h4321);
    check("R7", sx_t(out_t), 0, "truncated output after wrap recovery");
    check("R7", sx_w(out_w), 0, "wide output after wrap recovery");

    // R8: random samples and junk, scoreboard compares every cycle
    phase = "R8";
    for (int n = 0; n < 200; n++) send(16'($urandom), 16'($urandom));
    for (int n = 0; n < 4; n++) send(16'd0, 16'd0);

    repeat (LAT + 2) drive(1'b0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule